// File: doc/BRIEF.md
# Double-data-rate burst-of-four SRAM model

This block is a synthesizable model of a small static memory. Reads and writes share one data bus, and every access moves a fixed burst of four beats. The model runs on a clock at twice the command rate. A phase input marks each slot as either a true-edge slot (`k_phase` = 1) or a complementary-edge slot (`k_phase` = 0). Commands are taken only in true-edge slots. Write and read beats occupy consecutive slots and alternate between the two slot kinds.

A write command stores its address in an internal buffer. The four data beats, each with a per-lane byte-enable mask, are then taken from the shared bus over the following slots. A read command drives its four beats back after a fixed latency and raises a valid flag for exactly those slots. The bus is released at all other times.

Commands must be spaced at least two command cycles apart. A command that breaks this rule, or that asks for a read and a write at once, is dropped and raises a sticky error flag.

Top module: `ddr4b_sram`

## Requirements
- R1: While and right after reset, `dq_valid` and `proto_err` are 0.
- R2: Commands are sampled only at clock edges where `k_phase` = 1. A request at an edge with `k_phase` = 0 has no effect on memory or outputs and does not set `proto_err`.
- R3: Once a command is accepted at edge E, a command at the next `k_phase` = 1 edge (E+2) is dropped and sets `proto_err`. A command at edge E+4 is accepted.
- R4: A request with `rd_req` and `wr_req` both high at a `k_phase` = 1 edge is dropped and sets `proto_err`. It does not block a command at the next `k_phase` = 1 edge.
- R5: For a write accepted at edge E, beat k (k = 0..3) is taken from `dq` at edge E+2+k. It goes to address (base + k) modulo the depth.
- R6: Byte lane i of a write beat covers `dq[8i+7:8i]`. It is written only if `bwe[i]` = 1 at that beat's edge, and masks may differ per beat.
- R7: For a read accepted at edge E, beat k holds the word at (base + k) modulo the depth. It is on `dq` from edge E+4+k until the next edge.
- R8: `dq_valid` is 1 exactly in the slots that follow the edges where read beats are launched, and 0 otherwise. `dq` is high impedance whenever `dq_valid` is 0.
- R9: `proto_err` stays at 1 until reset once it is set.
- R10: A read accepted at the first permitted edge after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, two slots per command cycle |
| rst | input | 1 | Synchronous active-high reset |
| k_phase | input | 1 | 1 marks a true-edge slot, 0 a complementary-edge slot |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| addr | input | AW | Burst base address |
| bwe | input | DW/8 | Per-lane write enable for the current write beat |
| dq | inout | DW | Shared data bus, high impedance when idle |
| dq_valid | output | 1 | Read beat being driven |
| proto_err | output | 1 | Sticky command-spacing or conflict error |

## Verification
If the command delay line is off by one stage, every read beat shifts a slot. The fault then shows as a misplaced `dq_valid` edge at the first read, within five slots of the command. A wrong write-beat address or lane mask stays hidden in storage until the affected word is read back. The bench therefore reads every address after a sweep of overlapping masked bursts. A faulty spacing guard shows on `proto_err` at the edge right after the offending request, and on `dq_valid` when a dropped read is launched anyway.

// File: rtl/ddr4b_pkg.sv
`timescale 1ns/1ps
package ddr4b_pkg;
  // beats per burst
  localparam int BEATS = 4;
  // slots from command edge to first write beat
  localparam int WR_OFS = 2;
  // slots from command edge to first read beat launch
  localparam int RD_OFS = 4;
  // command delay line length needed to reach the last read beat
  localparam int PIPE = RD_OFS + BEATS - 1;
endpackage

// File: rtl/ddr4b_cmd_ctl.sv
`timescale 1ns/1ps
module ddr4b_cmd_ctl (
  input  logic clk,
  input  logic rst,
  input  logic k_phase,
  input  logic rd_req,
  input  logic wr_req,
  output logic acc,
  output logic acc_rd,
  output logic proto_err
);
  logic blk_q;
  logic err_q;
  logic sample;
  logic bad;

  assign sample = k_phase & (rd_req | wr_req);
  // spacing violation or read/write conflict
  assign bad    = sample & (blk_q | (rd_req & wr_req));
  assign acc    = sample & ~bad;
  assign acc_rd = rd_req;
  assign proto_err = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (acc)          blk_q <= 1'b1;
      else if (k_phase) blk_q <= 1'b0;
      if (bad)          err_q <= 1'b1;
    end
  end

  // R9: error flag never clears outside reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

// File: rtl/ddr4b_burst_seq.sv
`timescale 1ns/1ps
module ddr4b_burst_seq #(
  parameter int AW = 4,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          k_phase,
  input  logic          acc,
  input  logic          acc_rd,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] bwe,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [BW-1:0] wbe,
  output logic [AW-1:0] raddr,
  output logic          rvalid
);
  import ddr4b_pkg::*;

  typedef struct packed {
    logic          vld;
    logic          rd;
    logic [AW-1:0] base;
  } cmd_t;

  cmd_t pq [PIPE];
  logic [BEATS-1:0] wr_hit;
  logic [BEATS-1:0] rd_hit;
  logic rvalid_q;

  // command delay line: the write buffer and the read schedule
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PIPE; i++) pq[i] <= '0;
    end else begin
      pq[0].vld  <= acc;
      pq[0].rd   <= acc_rd;
      pq[0].base <= addr;
      for (int i = 1; i < PIPE; i++) pq[i] <= pq[i-1];
    end
  end

  generate
    for (genvar k = 0; k < BEATS; k++) begin : g_hit
      assign wr_hit[k] = pq[WR_OFS-1+k].vld & ~pq[WR_OFS-1+k].rd;
      assign rd_hit[k] = pq[RD_OFS-1+k].vld &  pq[RD_OFS-1+k].rd;
    end
  endgenerate

  always_comb begin
    waddr = '0;
    raddr = '0;
    for (int k = 0; k < BEATS; k++) begin
      if (wr_hit[k]) waddr = pq[WR_OFS-1+k].base + AW'(k);
      if (rd_hit[k]) raddr = pq[RD_OFS-1+k].base + AW'(k);
    end
  end

  assign we  = |wr_hit;
  assign wbe = bwe & {BW{we}};

  always_ff @(posedge clk) begin
    if (rst) rvalid_q <= 1'b0;
    else     rvalid_q <= |rd_hit;
  end
  assign rvalid = rvalid_q;

  // R2: entries only come from true-edge slots
  p_k_only_r2: assert property (@(posedge clk) disable iff (rst)
    pq[0].vld |-> $past(k_phase));
  // R3: no two accepted commands one command cycle apart
  p_gap_r3: assert property (@(posedge clk) disable iff (rst)
    pq[0].vld |-> !pq[2].vld);
  // R5: at most one write beat per slot
  p_one_wr_beat_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));
  // R7: at most one read beat per slot, bursts start on true edges
  p_one_rd_beat_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_hit));
  p_valid_after_k_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid_q) |-> $past(k_phase));
  // R8: valid runs are whole bursts
  p_burst_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rvalid_q) |-> $past(rvalid_q, 4));
endmodule

// File: rtl/ddr4b_mem.sv
`timescale 1ns/1ps
module ddr4b_mem #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [DW/8-1:0] wbe,
  input  logic [DW-1:0]   wdata,
  input  logic [AW-1:0]   raddr,
  output logic [DW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = DW / 8;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  // byte-lane write, read-first registered read
  always_ff @(posedge clk) begin
    for (int i = 0; i < BW; i++)
      if (we && wbe[i]) mem[waddr][8*i +: 8] <= wdata[8*i +: 8];
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ddr4b_sram.sv
`timescale 1ns/1ps
module ddr4b_sram #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              k_phase,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [AW-1:0]     addr,
  input  logic [DW/8-1:0]   bwe,
  inout  wire  [DW-1:0]     dq,
  output logic              dq_valid,
  output logic              proto_err
);
  localparam int BW = DW / 8;

  logic          acc;
  logic          acc_rd;
  logic          we;
  logic [AW-1:0] waddr;
  logic [BW-1:0] wbe;
  logic [AW-1:0] raddr;
  logic          rvalid;
  logic [DW-1:0] rdata;

  ddr4b_cmd_ctl u_cmd (
    .clk(clk), .rst(rst), .k_phase(k_phase),
    .rd_req(rd_req), .wr_req(wr_req),
    .acc(acc), .acc_rd(acc_rd), .proto_err(proto_err)
  );

  ddr4b_burst_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk(clk), .rst(rst), .k_phase(k_phase),
    .acc(acc), .acc_rd(acc_rd), .addr(addr), .bwe(bwe),
    .we(we), .waddr(waddr), .wbe(wbe), .raddr(raddr), .rvalid(rvalid)
  );

  ddr4b_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wbe(wbe), .wdata(dq),
    .raddr(raddr), .rdata(rdata)
  );

  assign dq       = rvalid ? rdata : {DW{1'bz}};
  assign dq_valid = rvalid;
endmodule

// File: tb/sim_ddr4b_sram.sv
`timescale 1ns/1ps
module sim_ddr4b_sram;
  localparam int AW = 4, DW = 16, BW = 2, DEPTH = 16, NS = 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, kph, rd, wr;
  logic [AW-1:0] addr;
  logic [BW-1:0] bwe;
  logic [DW-1:0] drv;
  logic drv_en;
  wire  [DW-1:0] dq;
  wire  dv, perr;

  assign dq = drv_en ? drv : {DW{1'bz}};

  ddr4b_sram #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .k_phase(kph), .rd_req(rd), .wr_req(wr),
    .addr(addr), .bwe(bwe), .dq(dq), .dq_valid(dv), .proto_err(perr)
  );

  logic          s_rd [NS];
  logic          s_wr [NS];
  logic [AW-1:0] s_ad [NS];
  logic          s_de [NS];
  logic [DW-1:0] s_dd [NS];
  logic [BW-1:0] s_be [NS];
  logic          e_v  [NS];
  logic [DW-1:0] e_d  [NS];
  logic          e_er [NS];
  string         e_tag[NS];
  logic [DW-1:0] model [DEPTH];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [DW-1:0] pat(int seed, int k);
    return DW'(seed * 16'h1357 + k * 16'h0F0F + 16'hA5C3);
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_sched();
    for (int i = 0; i < NS; i++) begin
      s_rd[i] = 0; s_wr[i] = 0; s_ad[i] = '0; s_de[i] = 0; s_dd[i] = '0;
      s_be[i] = '0; e_v[i] = 0; e_d[i] = '0; e_er[i] = 0; e_tag[i] = "R7";
    end
  endtask

  // masks: two bits per beat, beat k in bits [2k+1:2k]
  task automatic sch_write(int s, int base, int seed, logic [7:0] masks);
    s_wr[s] = 1; s_ad[s] = AW'(base);
    for (int k = 0; k < 4; k++) begin
      logic [DW-1:0] d;
      logic [BW-1:0] m;
      int a;
      d = pat(seed, k); m = masks[2*k +: 2]; a = (base + k) % DEPTH;
      s_de[s+2+k] = 1; s_dd[s+2+k] = d; s_be[s+2+k] = m;
      for (int i = 0; i < BW; i++)
        if (m[i]) model[a][8*i +: 8] = d[8*i +: 8];
    end
  endtask

  task automatic sch_read(int s, int base, string tag);
    s_rd[s] = 1; s_ad[s] = AW'(base);
    for (int k = 0; k < 4; k++) begin
      e_v[s+4+k] = 1; e_d[s+4+k] = model[(base + k) % DEPTH]; e_tag[s+4+k] = tag;
    end
  endtask

  task automatic sch_err_from(int s);
    for (int i = s; i < NS; i++) e_er[i] = 1;
  endtask

  task automatic run(int n);
    rst = 1; rd = 0; wr = 0; drv_en = 0; kph = 0; addr = '0; bwe = '0; drv = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dv == 1'b0, "R1", DW'(dv), '0);
    check(perr == 1'b0, "R1", DW'(perr), '0);
    rst = 0;
    for (int s = 0; s < n; s++) begin
      kph = (s % 2 == 0); rd = s_rd[s]; wr = s_wr[s]; addr = s_ad[s];
      drv_en = s_de[s]; drv = s_dd[s]; bwe = s_be[s];
      @(negedge clk);
      check(dv == e_v[s], "R8", DW'(dv), DW'(e_v[s]));
      if (e_v[s]) check(dq == e_d[s], e_tag[s], dq, e_d[s]);
      check(perr == e_er[s], "R9", DW'(perr), DW'(e_er[s]));
    end
  endtask

  initial begin
    // run A: fill, masked sweep, readback, coherency, odd-slot requests
    clear_sched();
    for (int b = 0; b < 4; b++) sch_write(4*b, 4*b, 100 + b, 8'hFF);
    for (int b = 0; b < 16; b++) begin
      logic [7:0] m;
      for (int k = 0; k < 4; k++) m[2*k +: 2] = 2'((b + k) % 4);
      sch_write(16 + 4*b, b, b, m);  // R6 masked overlapping bursts
    end
    for (int b = 0; b < 16; b++)
      sch_read(80 + 4*b, b, (b < 4) ? "R7" : ((b > 12) ? "R5" : "R6"));
    sch_write(152, 5, 77, 8'hFF);
    sch_read(156, 5, "R10");
    s_wr[161] = 1; s_ad[161] = 3;     // R2: odd slot, ignored
    s_rd[169] = 1; s_ad[169] = 3;     // R2: odd slot, ignored
    sch_read(172, 3, "R2");
    run(184);

    // run B: spacing violation
    clear_sched();
    sch_read(0, 0, "R3");
    s_rd[2] = 1; s_ad[2] = 4;         // R3: dropped
    sch_err_from(2);
    sch_read(4, 8, "R3");
    run(16);

    // run C: read and write together, then recovery
    clear_sched();
    s_rd[0] = 1; s_wr[0] = 1; s_ad[0] = 1;  // R4: dropped
    sch_err_from(0);
    sch_read(2, 1, "R4");
    run(14);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule